// File: doc/BRIEF.md
# Full-Period Random One-Hot Selector

This block is a clocked pseudo-random stimulus source. On each enabled clock it advances a shift register with XOR feedback and uses four of its stages as a 4-bit index. That index is decoded into a registered 16-wide one-hot select. It is meant to drive test stimulus that has to land on one of sixteen targets in an irregular but repeatable order, at a slow fixed step rate of about 12.5 kHz.

The feedback is the XOR of stages 14 and 13 of a 16-bit register. The loop therefore covers stages 14..0, and stage 15 is a one-step delayed copy of stage 14. A plain XOR loop never reaches the all-zero state, and this skews the index slightly toward nonzero values. When `full_period` is high, the block detects the state in which stages 13..0 are all zero and inverts the feedback. The loop then passes through zero once per period, the period grows from 2^15-1 to 2^15 steps, and every index value occurs equally often. A one-cycle `wrap_pulse` marks each return to the seed, which makes the period easy to measure.

Top module: `rand_onehot_sel`

## Requirements
- R1: While `rst` is high at a clock edge, `lfsr_q` becomes 0x0001, `sel_idx` becomes 1, `sel_onehot` becomes 0x0002 and `wrap_pulse` becomes 0.
- R2: On an edge with `step_en` high, `lfsr_q` shifts one place toward the MSB, and the new bit 0 is `lfsr_q[14] ^ lfsr_q[13]`. The one exception is the extension point of R4. Bit 15 therefore takes the old bit 14.
- R3: On an edge with `step_en` low, `lfsr_q`, `sel_idx` and `sel_onehot` keep their values and `wrap_pulse` goes to 0, whatever `full_period` is.
- R4: With `full_period` high, the feedback bit is inverted when `lfsr_q[13:0]` is all zero. Bits 14..0 then step from 0x4000 to 0x0000 and on to 0x0001, and the period is 32768 steps.
- R5: With `full_period` low, bits 14..0 never become zero when started from the seed, and the period is 32767 steps.
- R6: `sel_idx` equals `lfsr_q[3:0]`, and `sel_onehot` has exactly bit `sel_idx` set in every cycle after reset. It is never all zeros.
- R7: `wrap_pulse` is high for exactly one cycle, right after an enabled step that returns bits 14..0 to the seed value 0x0001. This happens once per period.
- R8: Over one full period in extension mode, each of the 16 index values occurs 2048 times. Without extension, index 0 occurs 2047 times and every other value occurs 2048 times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance one state on this edge |
| full_period | input | 1 | 1: insert the all-zero loop state (period 2^15) |
| sel_onehot | output | 16 | Registered one-hot select, bit `sel_idx` set |
| sel_idx | output | 4 | Raw index, register stages 3..0 |
| lfsr_q | output | 16 | Shift register state |
| wrap_pulse | output | 1 | One-cycle marker on return to seed |

## Verification
Every result is due on the same edge that takes the step, or one register after the inputs are presented. `lfsr_q`, `sel_idx`, `sel_onehot` and `wrap_pulse` all reflect a step at that edge, because the one-hot and wrap registers are loaded from the next-state value rather than from the current one. The bench changes inputs on the falling edge and samples 1 ns after the rising edge, so each check reads the result of exactly one step. The full-period runs count the steps up to the single wrap, check the zero insertion against the state before it and the state after it, and check the index histogram against R8.

// File: rtl/rsel_pkg.sv
package rsel_pkg;
   // Feedback polarity: XOR loops exclude all-zero, XNOR loops exclude all-one
   typedef enum logic {FB_XOR = 1'b0, FB_XNOR = 1'b1} fb_kind_e;

   localparam int unsigned DEF_WIDTH = 16;
   localparam int unsigned DEF_TAP_A = 14;
   localparam int unsigned DEF_TAP_B = 13;
   localparam int unsigned DEF_IDX_W = 4;
endpackage

// File: rtl/rsel_lfsr_core.sv
module rsel_lfsr_core
   import rsel_pkg::*;
#(
   parameter int unsigned WIDTH   = DEF_WIDTH,
   parameter int unsigned TAP_A   = DEF_TAP_A,
   parameter int unsigned TAP_B   = DEF_TAP_B,
   parameter logic [WIDTH-1:0] SEED = WIDTH'(1),
   parameter fb_kind_e    FB_KIND = FB_XOR
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             ext,
   output logic [WIDTH-1:0] state_q,
   output logic [WIDTH-1:0] state_d
);
   localparam int unsigned LOOP = TAP_A + 1;
   localparam logic [LOOP-1:0] LOCK =
      (FB_KIND == FB_XOR) ? {LOOP{1'b0}} : {LOOP{1'b1}};
   localparam logic [LOOP-2:0] FILL = LOCK[LOOP-2:0];

   initial begin : elab_chk
      if (TAP_A <= TAP_B) $error("TAP_A must be above TAP_B");
      if (TAP_A >= WIDTH) $error("TAP_A must lie inside the register");
      if (SEED[LOOP-1:0] == LOCK) $error("SEED loop bits equal the lock state");
   end

   logic fb_raw;
   logic at_ext_point;
   logic fb;

   generate
      if (FB_KIND == FB_XOR) begin : g_fb_xor
         assign fb_raw = state_q[TAP_A] ^ state_q[TAP_B];
      end else begin : g_fb_xnor
         assign fb_raw = ~(state_q[TAP_A] ^ state_q[TAP_B]);
      end
   endgenerate

   // Every loop bit except the one about to leave matches the lock fill
   assign at_ext_point = (state_q[LOOP-2:0] == FILL);
   assign fb           = fb_raw ^ (ext & at_ext_point);

   always_comb begin
      state_d = state_q;
      if (en) state_d = {state_q[WIDTH-2:0], fb};
   end

   always_ff @(posedge clk) begin
      if (rst) state_q <= SEED;
      else     state_q <= state_d;
   end

   // R3: hold when not enabled
   p_hold_r3: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(state_q));

   // R4: the inserted lock state is left for its successor on the next step
   p_ext_exit_r4: assert property (@(posedge clk) disable iff (rst)
      (en && ext && state_q[LOOP-1:0] == LOCK) |=>
         (state_q[LOOP-1:0] == (LOCK ^ LOOP'(1))));

   // R5: without extension the loop never enters the lock state
   p_no_lock_r5: assert property (@(posedge clk) disable iff (rst)
      (en && !ext && state_q[LOOP-1:0] != LOCK) |=>
         (state_q[LOOP-1:0] != LOCK));

   // R2: shift by one place on an enabled step
   p_shift_r2: assert property (@(posedge clk) disable iff (rst)
      en |=> (state_q[WIDTH-1:1] == $past(state_q[WIDTH-2:0])));
endmodule

// File: rtl/rsel_onehot_dec.sv
module rsel_onehot_dec #(
   parameter int unsigned WIDTH   = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned IDX_LSB = 0,
   parameter logic [WIDTH-1:0] SEED = WIDTH'(1)
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    en,
   input  logic [WIDTH-1:0]        state_q,
   input  logic [WIDTH-1:0]        state_d,
   output logic [IDX_W-1:0]        idx,
   output logic [(1<<IDX_W)-1:0]   onehot_q
);
   localparam int unsigned OUT_W = 1 << IDX_W;

   initial begin : elab_chk
      if (IDX_LSB + IDX_W > WIDTH) $error("index field exceeds register");
   end

   logic [IDX_W-1:0] idx_d;
   logic [IDX_W-1:0] idx_seed;
   logic [OUT_W-1:0] onehot_d;
   logic [OUT_W-1:0] onehot_seed;

   assign idx      = state_q[IDX_LSB +: IDX_W];
   assign idx_d    = state_d[IDX_LSB +: IDX_W];
   assign idx_seed = SEED[IDX_LSB +: IDX_W];

   for (genvar i = 0; i < OUT_W; i++) begin : g_dec
      assign onehot_d[i]    = (idx_d == IDX_W'(i));
      assign onehot_seed[i] = (idx_seed == IDX_W'(i));
   end

   // Loaded from the next state so it lines up with state_q
   always_ff @(posedge clk) begin
      if (rst)     onehot_q <= onehot_seed;
      else if (en) onehot_q <= onehot_d;
   end

   // R6: exactly one bit set
   p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
      $countones(onehot_q) == 1);
endmodule

// File: rtl/rsel_wrap_det.sv
module rsel_wrap_det #(
   parameter int unsigned LOOP = 15,
   parameter logic [LOOP-1:0] SEED_LOOP = LOOP'(1)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic            en,
   input  logic [LOOP-1:0] loop_d,
   output logic            wrap_q
);
   always_ff @(posedge clk) begin
      if (rst) wrap_q <= 1'b0;
      else     wrap_q <= en & (loop_d == SEED_LOOP);
   end

   // R7: a pulse never lasts two cycles without a fresh step
   p_wrap_single_r7: assert property (@(posedge clk) disable iff (rst)
      wrap_q |=> (!wrap_q || $past(en)));
endmodule

// File: rtl/rand_onehot_sel.sv
module rand_onehot_sel
   import rsel_pkg::*;
#(
   parameter int unsigned WIDTH   = DEF_WIDTH,
   parameter int unsigned TAP_A   = DEF_TAP_A,
   parameter int unsigned TAP_B   = DEF_TAP_B,
   parameter int unsigned IDX_W   = DEF_IDX_W,
   parameter int unsigned IDX_LSB = 0,
   parameter logic [WIDTH-1:0] SEED = WIDTH'(1),
   parameter fb_kind_e    FB_KIND = FB_XOR
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  step_en,
   input  logic                  full_period,
   output logic [(1<<IDX_W)-1:0] sel_onehot,
   output logic [IDX_W-1:0]      sel_idx,
   output logic [WIDTH-1:0]      lfsr_q,
   output logic                  wrap_pulse
);
   localparam int unsigned LOOP = TAP_A + 1;

   initial begin : elab_chk
      if (IDX_LSB + IDX_W > LOOP) $error("index must come from loop stages");
   end

   logic [WIDTH-1:0] state_d;

   rsel_lfsr_core #(
      .WIDTH(WIDTH), .TAP_A(TAP_A), .TAP_B(TAP_B),
      .SEED(SEED), .FB_KIND(FB_KIND)
   ) u_core (
      .clk(clk), .rst(rst), .en(step_en), .ext(full_period),
      .state_q(lfsr_q), .state_d(state_d)
   );

   rsel_onehot_dec #(
      .WIDTH(WIDTH), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB), .SEED(SEED)
   ) u_dec (
      .clk(clk), .rst(rst), .en(step_en),
      .state_q(lfsr_q), .state_d(state_d),
      .idx(sel_idx), .onehot_q(sel_onehot)
   );

   rsel_wrap_det #(
      .LOOP(LOOP), .SEED_LOOP(SEED[LOOP-1:0])
   ) u_wrap (
      .clk(clk), .rst(rst), .en(step_en),
      .loop_d(state_d[LOOP-1:0]), .wrap_q(wrap_pulse)
   );

   // R6: the registered one-hot matches the index from the state register
   p_onehot_match_r6: assert property (@(posedge clk) disable iff (rst)
      sel_onehot == ((1<<IDX_W))'(1) << sel_idx);

   // R7: a wrap pulse coincides with the seed in the loop stages
   p_wrap_seed_r7: assert property (@(posedge clk) disable iff (rst)
      wrap_pulse |-> (lfsr_q[LOOP-1:0] == SEED[LOOP-1:0]));
endmodule

// File: tb/rand_onehot_sel_tb.sv
`timescale 1ns/1ps
module rand_onehot_sel_tb;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        step_en = 1'b0;
   logic        full_period = 1'b0;
   logic [15:0] sel_onehot;
   logic [3:0]  sel_idx;
   logic [15:0] lfsr_q;
   logic        wrap_pulse;

   int n_run  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   rand_onehot_sel u_dut (
      .clk(clk), .rst(rst), .step_en(step_en), .full_period(full_period),
      .sel_onehot(sel_onehot), .sel_idx(sel_idx), .lfsr_q(lfsr_q),
      .wrap_pulse(wrap_pulse)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic en, input logic ext);
      @(negedge clk);
      step_en = en; full_period = ext;
      @(posedge clk);
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; step_en = 1'b1; full_period = 1'b1;
      @(posedge clk); @(posedge clk);
      #1;
      @(negedge clk);
      rst = 1'b0; step_en = 1'b0;
   endtask

   // {step_en, full_period, expected lfsr_q} from the seed 0x0001
   localparam int NV = 18;
   localparam logic [17:0] VEC [NV] = '{
      {1'b1, 1'b1, 16'h0002}, {1'b0, 1'b0, 16'h0002}, {1'b1, 1'b0, 16'h0004},
      {1'b1, 1'b1, 16'h0008}, {1'b0, 1'b1, 16'h0008}, {1'b1, 1'b0, 16'h0010},
      {1'b1, 1'b1, 16'h0020}, {1'b1, 1'b0, 16'h0040}, {1'b1, 1'b1, 16'h0080},
      {1'b1, 1'b0, 16'h0100}, {1'b1, 1'b1, 16'h0200}, {1'b1, 1'b0, 16'h0400},
      {1'b1, 1'b1, 16'h0800}, {1'b1, 1'b0, 16'h1000}, {1'b1, 1'b1, 16'h2000},
      {1'b1, 1'b0, 16'h4001}, {1'b1, 1'b1, 16'h8003}, {1'b1, 1'b0, 16'h0006}
   };

   task automatic full_run(input logic ext, input int period);
      int hist [16];
      int wraps = 0, wrap_at = -1, zero_seen = 0, bad_hot = 0, bad_ins = 0;
      logic [14:0] prev;
      for (int k = 0; k < 16; k++) hist[k] = 0;
      prev = lfsr_q[14:0];
      for (int s = 1; s <= period; s++) begin
         step(1'b1, ext);
         hist[sel_idx]++;
         if (sel_onehot != (16'(1) << sel_idx) || sel_idx != lfsr_q[3:0]) bad_hot++;
         if (wrap_pulse) begin wraps++; wrap_at = s; end
         if (lfsr_q[14:0] == 15'h0) begin
            zero_seen++;
            if (prev != 15'h4000) bad_ins++;
         end
         if (prev == 15'h0 && lfsr_q[14:0] != 15'h0001) bad_ins++;
         prev = lfsr_q[14:0];
      end
      check(bad_hot == 0, "R6 one-hot/index mismatches", bad_hot, 0);
      check(wraps == 1, "R7 wrap count per period", wraps, 1);
      check(wrap_at == period, ext ? "R4 period length" : "R5 period length", wrap_at, period);
      check(lfsr_q[14:0] == 15'h0001, "R7 state at wrap", int'(lfsr_q), 1);
      if (ext) begin
         check(zero_seen == 1, "R4 zero loop state visits", zero_seen, 1);
         check(bad_ins == 0, "R4 insertion neighbours", bad_ins, 0);
      end else begin
         check(zero_seen == 0, "R5 zero loop state visits", zero_seen, 0);
      end
      for (int k = 0; k < 16; k++) begin
         int exp_n = (!ext && k == 0) ? 2047 : 2048;
         check(hist[k] == exp_n, $sformatf("R8 histogram idx %0d", k), hist[k], exp_n);
      end
      step(1'b0, ext);
      check(wrap_pulse == 1'b0, "R7 pulse lasts one cycle", int'(wrap_pulse), 0);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      do_reset();
      #1;
      // R1: reset state
      check(lfsr_q == 16'h0001, "R1 reset lfsr_q", int'(lfsr_q), 1);
      check(sel_idx == 4'd1, "R1 reset sel_idx", int'(sel_idx), 1);
      check(sel_onehot == 16'h0002, "R1 reset sel_onehot", int'(sel_onehot), 2);
      check(wrap_pulse == 1'b0, "R1 reset wrap_pulse", int'(wrap_pulse), 0);

      // R2/R3/R6: vector walk
      for (int v = 0; v < NV; v++) begin
         step(VEC[v][17], VEC[v][16]);
         check(lfsr_q == VEC[v][15:0], $sformatf("R2 R3 vector %0d lfsr_q", v),
               int'(lfsr_q), int'(VEC[v][15:0]));
         check(sel_onehot == (16'(1) << VEC[v][3:0]), $sformatf("R6 vector %0d onehot", v),
               int'(sel_onehot), int'(16'(1) << VEC[v][3:0]));
      end

      // R3: hold with mode toggling
      for (int h = 0; h < 4; h++) begin
         step(1'b0, h[0]);
         check(lfsr_q == 16'h0006 && sel_idx == 4'd6 && sel_onehot == 16'h0040,
               "R3 hold while disabled", int'(lfsr_q), 6);
         check(wrap_pulse == 1'b0, "R3 no wrap while disabled", int'(wrap_pulse), 0);
      end

      // R1: reset mid-run with enable high
      do_reset();
      #1;
      check(lfsr_q == 16'h0001 && sel_onehot == 16'h0002, "R1 reset mid-run",
            int'(lfsr_q), 1);

      // R4, R7, R8: extended full period
      full_run(1'b1, 32768);

      // R5, R7, R8: plain full period
      do_reset();
      full_run(1'b0, 32767);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule